// File: doc/BRIEF.md
# Virtual Function Uncorrectable Error Status Register

This block holds the 32-bit uncorrectable error status word of one virtual function on a serial-link endpoint. Five error conditions are implemented. Each one is raised by a single-cycle hardware event pulse and stays latched until it is cleared. The other defined error positions and all reserved positions always read as zero for a virtual function.

Two write paths can clear latched errors with write-1-to-clear semantics: the configuration write port, shared by software and firmware, and a local management port. When the error-emulation enable input is high, a configuration write stops clearing bits and loads the written value directly into the implemented bits. Firmware uses this to inject errors. The latched bits are sticky: a hot or function-level reset leaves them unchanged, and only the asynchronous power-on reset returns them to zero.

The live status word is always available at an output for the neighbouring message logic. A registered read port returns a snapshot of the word one cycle after a read request.

Top module: `vf_uerr_status`

## Requirements
- R1: The event input `evt_i` maps onto status bits as follows: [0] poisoned packet received to bit 12, [1] completion timeout to bit 14, [2] completer abort returned to bit 15, [3] unexpected completion to bit 16, [4] unsupported request to bit 20. A pulse on an event bit sets its status bit at the next clock edge.
- R2: Bits 4, 13, 17, 18, 19 and 22 and the reserved bits 3:0, 11:5, 21 and 31:23 always read 0, on `status_o` and on `rd_data_o`, including after an emulation write of all ones. The implemented-bit mask is therefore 32'h0011_D000.
- R3: A configuration write with `emu_en` low clears each implemented bit whose data bit is 1. Data bits of 0 leave the status unchanged.
- R4: A management write clears each implemented bit whose data bit is 1, whatever `emu_en` is. In the same cycle, this clear also applies on top of a configuration write.
- R5: A configuration write with `emu_en` high loads the implemented bits with the written data bits at their positions, setting or clearing them.
- R6: An event on a bit in the same cycle as a clear or a load of that bit leaves the bit set.
- R7: Asserting the synchronous hot reset (`hot_rst_n` low) leaves every status bit unchanged. Asserting the asynchronous power-on reset (`por_rst_n` low) forces the status to 0 at once.
- R8: If `rd_en` is high at a clock edge while `hot_rst_n` is high, then after that edge `rd_valid_o` is 1 and `rd_data_o` holds the status word from before the edge. Otherwise, after the edge `rd_valid_o` is 0 and `rd_data_o` is 0.
- R9: When there is no event and no write, the status word holds its value indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Asynchronous power-on reset, active low; clears sticky bits |
| hot_rst_n | input | 1 | Synchronous hot / function-level reset, active low; clears only the read pipeline |
| evt_i | input | 5 | Single-cycle error event pulses, one per implemented bit |
| cfg_wr_en | input | 1 | Configuration (software/firmware) write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| emu_en | input | 1 | Error-emulation enable; turns configuration writes into direct loads |
| mgmt_wr_en | input | 1 | Local management write strobe (write-1-to-clear) |
| mgmt_wr_data | input | 32 | Local management write data |
| rd_en | input | 1 | Read request |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data_o | output | 32 | Registered read data |
| status_o | output | 32 | Live status word |

## Verification
Events and writes take effect at the clock edge that samples them, so `status_o` shows the result one edge later. A read shows up on `rd_valid_o` and `rd_data_o` after that same edge, carrying the word from before the edge. The bench drives all inputs at the falling edge. After the next rising edge it updates its reference model, and it compares every output at the following falling edge. Read data is therefore compared against the reference word saved before the model update, so a read in the same cycle as an event must return the old value.

// File: rtl/vf_uerr_pkg.sv
package vf_uerr_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned NUM_ERR = 5;

    // Status bit position of each event input; neighbours decode these.
    localparam int unsigned ERR_POS [NUM_ERR] = '{12, 14, 15, 16, 20};

    typedef struct packed {
        logic flag;
    } cell_state_t;

    typedef struct packed {
        logic             rd_valid;
        logic [REG_W-1:0] rd_data;
    } rd_state_t;

    function automatic logic [NUM_ERR-1:0] gather(input logic [REG_W-1:0] w);
        logic [NUM_ERR-1:0] r;
        r = '0;
        for (int unsigned i = 0; i < NUM_ERR; i++) begin
            r[i] = w[ERR_POS[i]];
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] scatter(input logic [NUM_ERR-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        for (int unsigned i = 0; i < NUM_ERR; i++) begin
            r[ERR_POS[i]] = v[i];
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] impl_mask();
        return scatter('1);
    endfunction

endpackage

// File: rtl/vf_uerr_wr_decode.sv
module vf_uerr_wr_decode
    import vf_uerr_pkg::*;
#(
    parameter int unsigned DW = REG_W,
    parameter int unsigned NE = NUM_ERR
) (
    input  logic          cfg_wr_en,
    input  logic [DW-1:0] cfg_wr_data,
    input  logic          emu_en,
    input  logic          mgmt_wr_en,
    input  logic [DW-1:0] mgmt_wr_data,
    output logic [NE-1:0] clr_o,
    output logic          ld_en_o,
    output logic [NE-1:0] ld_val_o
);

    logic [NE-1:0] cfg_bits;
    logic [NE-1:0] mgmt_bits;

    always_comb begin
        cfg_bits  = gather(cfg_wr_data);
        mgmt_bits = gather(mgmt_wr_data);

        ld_en_o  = cfg_wr_en & emu_en;
        ld_val_o = cfg_bits;

        clr_o = '0;
        if (mgmt_wr_en) begin
            clr_o = clr_o | mgmt_bits;
        end
        if (cfg_wr_en && !emu_en) begin
            clr_o = clr_o | cfg_bits;
        end
    end

endmodule

// File: rtl/vf_uerr_sticky_cell.sv
module vf_uerr_sticky_cell
    import vf_uerr_pkg::*;
(
    input  logic clk,
    input  logic por_rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ld_en_i,
    input  logic ld_val_i,
    output logic flag_o
);

    cell_state_t st_d;
    cell_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (ld_en_i) begin
            st_d.flag = ld_val_i;
        end
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/vf_uerr_read_port.sv
module vf_uerr_read_port
    import vf_uerr_pkg::*;
#(
    parameter int unsigned DW = REG_W
) (
    input  logic          clk,
    input  logic          por_rst_n,
    input  logic          hot_rst_n,
    input  logic          rd_en,
    input  logic [DW-1:0] word_i,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o
);

    rd_state_t rd_d;
    rd_state_t rd_q;

    always_comb begin
        rd_d          = '0;
        if (hot_rst_n && rd_en) begin
            rd_d.rd_valid = 1'b1;
            rd_d.rd_data  = word_i;
        end
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.rd_valid;
    assign rd_data_o  = rd_q.rd_data;

endmodule

// File: rtl/vf_uerr_status.sv
module vf_uerr_status
    import vf_uerr_pkg::*;
(
    input  logic               clk,
    input  logic               por_rst_n,
    input  logic               hot_rst_n,
    input  logic [NUM_ERR-1:0] evt_i,
    input  logic               cfg_wr_en,
    input  logic [REG_W-1:0]   cfg_wr_data,
    input  logic               emu_en,
    input  logic               mgmt_wr_en,
    input  logic [REG_W-1:0]   mgmt_wr_data,
    input  logic               rd_en,
    output logic               rd_valid_o,
    output logic [REG_W-1:0]   rd_data_o,
    output logic [REG_W-1:0]   status_o
);

    logic [NUM_ERR-1:0] clr;
    logic               ld_en;
    logic [NUM_ERR-1:0] ld_val;
    logic [NUM_ERR-1:0] flags;
    logic [REG_W-1:0]   word;

    vf_uerr_wr_decode #(
        .DW (REG_W),
        .NE (NUM_ERR)
    ) u_dec (
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_data  (cfg_wr_data),
        .emu_en       (emu_en),
        .mgmt_wr_en   (mgmt_wr_en),
        .mgmt_wr_data (mgmt_wr_data),
        .clr_o        (clr),
        .ld_en_o      (ld_en),
        .ld_val_o     (ld_val)
    );

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_cell
        vf_uerr_sticky_cell u_cell (
            .clk       (clk),
            .por_rst_n (por_rst_n),
            .set_i     (evt_i[g]),
            .clr_i     (clr[g]),
            .ld_en_i   (ld_en),
            .ld_val_i  (ld_val[g]),
            .flag_o    (flags[g])
        );
    end

    always_comb begin
        word = scatter(flags);
    end

    vf_uerr_read_port #(
        .DW (REG_W)
    ) u_rd (
        .clk        (clk),
        .por_rst_n  (por_rst_n),
        .hot_rst_n  (hot_rst_n),
        .rd_en      (rd_en),
        .word_i     (word),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    assign status_o = word;

endmodule

// File: rtl/vf_uerr_status_chk.sv
module vf_uerr_status_chk
    import vf_uerr_pkg::*;
(
    input logic               clk,
    input logic               por_rst_n,
    input logic               hot_rst_n,
    input logic [NUM_ERR-1:0] evt_i,
    input logic               cfg_wr_en,
    input logic [REG_W-1:0]   cfg_wr_data,
    input logic               emu_en,
    input logic               mgmt_wr_en,
    input logic [REG_W-1:0]   mgmt_wr_data,
    input logic               rd_en,
    input logic               rd_valid_o,
    input logic [REG_W-1:0]   rd_data_o,
    input logic [REG_W-1:0]   status_o
);

    localparam logic [REG_W-1:0] IMPL = impl_mask();

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_rst_n)
        ((status_o & ~IMPL) == '0) && ((rd_data_o & ~IMPL) == '0)); // R2

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!por_rst_n)
        (evt_i != '0) |=> ((gather(status_o) & $past(evt_i)) == $past(evt_i))); // R6

    AST_CFG_W1C: assert property (@(posedge clk) disable iff (!por_rst_n)
        (cfg_wr_en && !emu_en && evt_i == '0)
        |=> ((gather(status_o) & gather($past(cfg_wr_data))) == '0)); // R3

    AST_MGMT_W1C: assert property (@(posedge clk) disable iff (!por_rst_n)
        (mgmt_wr_en && evt_i == '0)
        |=> ((gather(status_o) & gather($past(mgmt_wr_data))) == '0)); // R4

    AST_EMU_LOAD: assert property (@(posedge clk) disable iff (!por_rst_n)
        (cfg_wr_en && emu_en && !mgmt_wr_en && evt_i == '0)
        |=> (gather(status_o) == gather($past(cfg_wr_data)))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!cfg_wr_en && !mgmt_wr_en && evt_i == '0) |=> $stable(status_o)); // R9

    AST_RD_SNAP: assert property (@(posedge clk) disable iff (!por_rst_n)
        (rd_en && hot_rst_n) |=> (rd_valid_o && rd_data_o == $past(status_o))); // R8

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!rd_en || !hot_rst_n) |=> (!rd_valid_o && rd_data_o == '0)); // R8

endmodule

bind vf_uerr_status vf_uerr_status_chk u_chk (.*);

// File: tb/vf_uerr_status_bench.sv
module vf_uerr_status_bench;

    localparam int CLK_P = 10;
    localparam logic [31:0] MASK = 32'h0011_D000;

    logic        clk = 1'b0;
    logic        por_rst_n = 1'b0;
    logic        hot_rst_n = 1'b1;
    logic [4:0]  evt_i = '0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        emu_en = 1'b0;
    logic        mgmt_wr_en = 1'b0;
    logic [31:0] mgmt_wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;
    logic [31:0] status_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_stat = '0;
    logic        exp_rv = 1'b0;
    logic [31:0] exp_rd = '0;

    always #(CLK_P/2) clk = ~clk;

    vf_uerr_status u_vf_uerr_status (
        .clk(clk), .por_rst_n(por_rst_n), .hot_rst_n(hot_rst_n), .evt_i(evt_i),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .emu_en(emu_en),
        .mgmt_wr_en(mgmt_wr_en), .mgmt_wr_data(mgmt_wr_data), .rd_en(rd_en),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .status_o(status_o)
    );

    function automatic logic [31:0] evt_mask(input logic [4:0] e);
        return {11'd0, e[4], 3'd0, e[3], e[2], e[1], 1'b0, e[0], 12'd0};
    endfunction

    function automatic logic [31:0] model(input logic [31:0] q, input logic [4:0] e,
                                          input logic cw, input logic [31:0] cd,
                                          input logic emu, input logic mw,
                                          input logic [31:0] md);
        logic [31:0] n;
        n = q;
        if (cw && emu)  n = cd;
        else if (cw)    n = n & ~cd;
        if (mw)         n = n & ~md;
        return (n | evt_mask(e)) & MASK;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] e, input logic cw, input logic [31:0] cd,
                        input logic emu, input logic mw, input logic [31:0] md,
                        input logic rd, input logic hot, input string tag);
        evt_i = e; cfg_wr_en = cw; cfg_wr_data = cd; emu_en = emu;
        mgmt_wr_en = mw; mgmt_wr_data = md; rd_en = rd; hot_rst_n = ~hot;
        @(posedge clk);
        exp_rv   = rd && !hot;
        exp_rd   = (rd && !hot) ? exp_stat : 32'h0;
        exp_stat = model(exp_stat, e, cw, cd, emu, mw, md);
        @(negedge clk);
        chk({tag, " status"}, status_o, exp_stat);
        chk({tag, " rd_valid"}, {31'd0, rd_valid_o}, {31'd0, exp_rv});
        chk({tag, " rd_data"}, rd_data_o, exp_rd);
    endtask

    task automatic idle(input string tag);
        step('0, 0, '0, 0, 0, '0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk("R7 por status", status_o, 32'h0);
        chk("R8 por rd_valid", {31'd0, rd_valid_o}, 32'h0);
        por_rst_n = 1'b1;
        @(negedge clk);

        // R1: each event sets its own bit
        for (int i = 0; i < 5; i++) step(5'(1 << i), 0, '0, 0, 0, '0, 0, 0, "R1");
        chk("R1 all events", status_o, 32'h0011_D000);

        // R3: zero write has no effect, one clears
        step('0, 1, 32'h0, 0, 0, '0, 0, 0, "R3 zero write");
        step('0, 1, 32'h0000_4000, 0, 0, '0, 0, 0, "R3 clear bit14");
        chk("R3 bit14 cleared", status_o, 32'h0011_9000);

        // R4: management clear, including while emulation enabled
        step('0, 0, '0, 1, 1, 32'h0000_1000, 0, 0, "R4 mgmt bit12");
        chk("R4 bit12 cleared", status_o, 32'h0011_8000);
        step('0, 0, '0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R4 mgmt all");
        chk("R4 all cleared", status_o, 32'h0);

        // R2: emulation write of all ones only lands in implemented bits
        step('0, 1, 32'hFFFF_FFFF, 1, 0, '0, 0, 0, "R2 emu ones");
        step('0, 0, '0, 0, 0, '0, 1, 0, "R2 read");
        chk("R2 rd_data masked", rd_data_o, 32'h0011_D000);

        // R5: emulation load sets and clears
        step('0, 1, 32'h0001_0010, 1, 0, '0, 0, 0, "R5 load");
        chk("R5 loaded", status_o, 32'h0001_0000);
        step('0, 1, 32'h0000_0000, 1, 0, '0, 0, 0, "R5 load zero");
        chk("R5 zero", status_o, 32'h0);

        // R6: event wins over clear and load
        step(5'h1F, 1, 32'hFFFF_FFFF, 0, 1, 32'hFFFF_FFFF, 0, 0, "R6 vs w1c");
        chk("R6 w1c", status_o, 32'h0011_D000);
        step(5'h01, 1, 32'h0, 1, 0, '0, 0, 0, "R6 vs load");
        chk("R6 load", status_o, 32'h0000_1000);
        step(5'h10, 1, 32'h0, 1, 1, 32'hFFFF_FFFF, 0, 0, "R6 vs load+mgmt");
        chk("R6 load+mgmt", status_o, 32'h0010_0000);

        // R8: read snapshot precedes same-cycle event
        step(5'h02, 0, '0, 0, 0, '0, 1, 0, "R8 snap");
        chk("R8 old value", rd_data_o, 32'h0010_0000);
        chk("R8 new status", status_o, 32'h0010_4000);

        // R7: hot reset keeps sticky bits, drops read
        for (int i = 0; i < 4; i++) step('0, 0, '0, 0, 0, '0, 1, 1, "R7 hot");
        chk("R7 sticky", status_o, 32'h0010_4000);

        // R9: long hold
        for (int i = 0; i < 20; i++) idle("R9 hold");
        chk("R9 held", status_o, 32'h0010_4000);

        // R7: power-on reset clears immediately
        por_rst_n = 1'b0;
        #1;
        chk("R7 por clears", status_o, 32'h0);
        chk("R8 por rd", {31'd0, rd_valid_o}, 32'h0);
        exp_stat = '0;
        @(negedge clk);
        por_rst_n = 1'b1;
        @(negedge clk);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [4:0]  e;
            logic [31:0] cd, md;
            for (int b = 0; b < 5; b++) e[b] = ($urandom_range(9) == 0);
            cd = $urandom();
            md = ($urandom_range(1) == 0) ? $urandom() : (32'h1 << $urandom_range(31));
            step(e, $urandom_range(4) == 0, cd, $urandom_range(3) == 0,
                 $urandom_range(6) == 0, md, $urandom_range(1) == 0,
                 $urandom_range(30) == 0, "RND");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule